// File: doc/BRIEF.md
# Four-Lane Deskew Aligner

This block sits between four per-lane word aligners and a rate-matching stage. The lanes arrive already byte-framed, but each one may be delayed by a different number of cycles. Each lane delivers three things per cycle: a decoded character, a flag that marks the character as control, and a flag that says the lane holds byte sync. The block looks for the alignment control character (K28.3, value 0x7C with the control flag set) on every lane. It queues each lane in a small buffer, starting at that lane's first alignment character. Once all four lanes have seen one, it drains the four buffers together, so that matching columns leave in the same cycle.

A lock controller watches the released columns. It declares alignment after a run of alignment columns that are complete on all lanes. After that it tolerates an isolated broken column, and it gives up after a run of broken ones. The block restarts its search, flushing every buffer, in three cases: when any lane loses sync, when skew exceeds the buffer depth, or when a column breaks before lock.

Top module: `lane_deskew`

## Requirements
- R1: A lane starts buffering only on an alignment character, meaning the control flag is 1 and the data is 0x7C. Neither 0x7C with the control flag at 0, nor a control character of another value such as 0xBC, starts a lane.
- R2: Output is released one cycle after the clock edge at which the last lane sees its first alignment character. The first released column holds the alignment character on all four lanes. Every later column carries, on all four lanes, characters from one common source column, with one new column per cycle.
- R3: Skew between the earliest and latest lane of up to FIFO_DEPTH-1 cycles (15 by default) is absorbed without loss or restart.
- R4: If the other lanes still lack a start FIFO_DEPTH edges after the first lane started, the block restarts and releases nothing. An alignment character arriving on that restart edge is dropped.
- R5: `aligned` rises on the edge after the fourth consecutive complete alignment column is presented at the output.
- R6: While aligned, a single broken column (alignment character on some lanes but not all) followed by a complete one leaves `aligned` and the data stream untouched.
- R7: While aligned, four broken alignment columns with no complete one between them clear `aligned` and `out_valid` on the edge after the fourth is presented, and the search restarts.
- R8: Before lock, any broken alignment column clears `out_valid` on the next edge and restarts the search.
- R9: A 0 on any lane's sync input clears `out_valid` and `aligned` on the next edge and flushes all buffers. This takes priority over a lock that would complete on the same edge.
- R10: During and directly after reset, `out_valid` and `aligned` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | LANES*DATA_W | Per-lane decoded character, lane 0 in the low bits |
| in_ctrl | input | LANES | Per-lane control-character flag |
| in_sync | input | LANES | Per-lane byte-sync flag from the word aligner |
| out_data | output | LANES*DATA_W | Deskewed characters, lane 0 in the low bits |
| out_ctrl | output | LANES | Deskewed control flags |
| out_valid | output | 1 | Released columns are present on the outputs |
| aligned | output | 1 | Lock status |

## Verification
Two functions can fall on the same edge: a restart, and an event it must override. The bench provokes both cases. In the first, the loss-of-sync input falls exactly on the edge where the fourth complete column would set `aligned`. In the second, a 16-cycle lane skew makes the late lane's first alignment character land on the overflow-restart edge. Both are judged by computing in the bench, from the skews and the marker period alone, the cycle in which `out_valid` and `aligned` must be low, and the later column where acquisition must begin again.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
   // Lock controller state: hunting for lock, or holding it
   typedef enum logic [0:0] {
      LK_HUNT = 1'b0,
      LK_HELD = 1'b1
   } lock_state_e;

   // Default alignment control character (K28.3)
   localparam logic [7:0] DSK_ALIGN_K = 8'h7C;
endpackage

// File: rtl/dsk_lane_fifo.sv
`timescale 1ns/1ps
module dsk_lane_fifo #(
   parameter int unsigned WIDTH = 9,
   parameter int unsigned DEPTH = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flush,
   input  logic                     wr_en,
   input  logic [WIDTH-1:0]         wr_data,
   input  logic                     rd_en,
   output logic [WIDTH-1:0]         rd_data,
   output logic [$clog2(DEPTH):0]   level
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned LW = AW + 1;

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr;
   logic [AW-1:0]    rd_ptr;

   // Pointers and occupancy; a flush empties the queue at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (wr_en) wr_ptr <= wr_ptr + 1'b1;
         if (rd_en) rd_ptr <= rd_ptr + 1'b1;
         level <= level + LW'(wr_en) - LW'(rd_en);
      end
   end

   // Storage carries no reset
   always_ff @(posedge clk) begin
      if (wr_en && !flush) mem[wr_ptr] <= wr_data;
   end

   // Registered read port; a full queue may be written and read on one edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                rd_data <= '0;
      else if (rd_en && !flush)  rd_data <= mem[rd_ptr];
   end
endmodule

// File: rtl/dsk_lock_fsm.sv
`timescale 1ns/1ps
module dsk_lock_fsm
   import dsk_pkg::*;
#(
   parameter int unsigned LANES     = 4,
   parameter int unsigned LOCK_COLS = 4,
   parameter int unsigned LOSS_COLS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             force_restart,
   input  logic             col_valid,
   input  logic [LANES-1:0] col_marks,
   output logic             aligned,
   output logic             drop_req
);
   localparam int unsigned GW = $clog2(LOCK_COLS + 1);
   localparam int unsigned BW = $clog2(LOSS_COLS + 1);

   lock_state_e   state;
   logic [GW-1:0] good_cnt;
   logic [BW-1:0] bad_cnt;
   logic          col_all;
   logic          col_bad;

   assign col_all = col_valid && (&col_marks);
   assign col_bad = col_valid && (|col_marks) && !(&col_marks);

   // Broken column: fatal while hunting, counted while held
   assign drop_req = col_bad &&
                     ((state == LK_HUNT) || (bad_cnt == BW'(LOSS_COLS - 1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LK_HUNT;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else if (force_restart || drop_req) begin
         state    <= LK_HUNT;
         good_cnt <= '0;
         bad_cnt  <= '0;
      end else if (col_all) begin
         if (state == LK_HUNT) begin
            if (good_cnt == GW'(LOCK_COLS - 1)) begin
               state    <= LK_HELD;
               good_cnt <= '0;
            end else begin
               good_cnt <= good_cnt + 1'b1;
            end
         end else begin
            bad_cnt <= '0;
         end
      end else if (col_bad) begin
         bad_cnt <= bad_cnt + 1'b1;
      end
   end

   assign aligned = (state == LK_HELD);
endmodule

// File: rtl/lane_deskew.sv
`timescale 1ns/1ps
module lane_deskew
   import dsk_pkg::*;
#(
   parameter int unsigned        LANES      = 4,
   parameter int unsigned        DATA_W     = 8,
   parameter int unsigned        FIFO_DEPTH = 16,
   parameter logic [DATA_W-1:0]  ALIGN_CODE = DATA_W'(DSK_ALIGN_K),
   parameter int unsigned        LOCK_COLS  = 4,
   parameter int unsigned        LOSS_COLS  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [LANES*DATA_W-1:0]   in_data,
   input  logic [LANES-1:0]          in_ctrl,
   input  logic [LANES-1:0]          in_sync,
   output logic [LANES*DATA_W-1:0]   out_data,
   output logic [LANES-1:0]          out_ctrl,
   output logic                      out_valid,
   output logic                      aligned
);
   localparam int unsigned SKW = $clog2(FIFO_DEPTH);
   localparam int unsigned LVW = SKW + 1;
   localparam int unsigned WW  = DATA_W + 1;

   // Elaboration-time parameter checks
   if (LANES != 4) begin : g_bad_lanes
      $error("lane_deskew: LANES must be 4");
   end
   if ((FIFO_DEPTH < 4) || ((FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)) begin : g_bad_depth
      $error("lane_deskew: FIFO_DEPTH must be a power of two, at least 4");
   end
   if ((LOCK_COLS < 1) || (LOSS_COLS < 1)) begin : g_bad_counts
      $error("lane_deskew: LOCK_COLS and LOSS_COLS must be at least 1");
   end
   if (DATA_W < 8) begin : g_bad_width
      $error("lane_deskew: DATA_W must be at least 8");
   end

   logic [LANES-1:0]      lane_mark;
   logic [LANES-1:0]      started;
   logic [LANES-1:0]      start_now;
   logic [LANES-1:0]      wr_en;
   logic [LANES-1:0]      col_marks;
   logic [LANES*LVW-1:0]  fifo_level;
   logic [SKW-1:0]        skew_cnt;
   logic                  any_st;
   logic                  all_st;
   logic                  sync_ok;
   logic                  skew_fail;
   logic                  ext_restart;
   logic                  drop_req;
   logic                  restart;
   logic                  rd_en;

   assign sync_ok     = &in_sync;
   assign any_st      = |started;
   assign all_st      = &started;
   assign skew_fail   = any_st && !all_st && (skew_cnt == SKW'(FIFO_DEPTH - 1));
   assign ext_restart = !sync_ok || skew_fail;
   assign restart     = ext_restart || drop_req;
   assign rd_en       = !restart && all_st;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [WW-1:0] rd_word;

      assign lane_mark[g] = in_ctrl[g] &&
                            (in_data[g*DATA_W +: DATA_W] == ALIGN_CODE);
      assign start_now[g] = !restart && !started[g] && lane_mark[g];
      assign wr_en[g]     = !restart && (started[g] || start_now[g]);

      dsk_lane_fifo #(
         .WIDTH (WW),
         .DEPTH (FIFO_DEPTH)
      ) u_fifo (
         .clk     (clk),
         .rst_n   (rst_n),
         .flush   (restart),
         .wr_en   (wr_en[g]),
         .wr_data ({in_ctrl[g], in_data[g*DATA_W +: DATA_W]}),
         .rd_en   (rd_en),
         .rd_data (rd_word),
         .level   (fifo_level[g*LVW +: LVW])
      );

      assign out_data[g*DATA_W +: DATA_W] = rd_word[DATA_W-1:0];
      assign out_ctrl[g]                  = rd_word[DATA_W];
      assign col_marks[g] = rd_word[DATA_W] && (rd_word[DATA_W-1:0] == ALIGN_CODE);
   end

   // Per-lane start flags and the skew window counter
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         started  <= '0;
         skew_cnt <= '0;
      end else begin
         started  <= restart ? '0 : (started | start_now);
         skew_cnt <= (restart || !any_st || all_st) ? '0 : (skew_cnt + 1'b1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= rd_en;
   end

   dsk_lock_fsm #(
      .LANES     (LANES),
      .LOCK_COLS (LOCK_COLS),
      .LOSS_COLS (LOSS_COLS)
   ) u_lock (
      .clk           (clk),
      .rst_n         (rst_n),
      .force_restart (ext_restart),
      .col_valid     (out_valid),
      .col_marks     (col_marks),
      .aligned       (aligned),
      .drop_req      (drop_req)
   );
endmodule

// File: rtl/dsk_checker.sv
`timescale 1ns/1ps
module dsk_checker #(
   parameter int unsigned        LANES      = 4,
   parameter int unsigned        DATA_W     = 8,
   parameter int unsigned        FIFO_DEPTH = 16,
   parameter logic [DATA_W-1:0]  ALIGN_CODE = 'h7C
) (
   input logic                                   clk,
   input logic                                   rst_n,
   input logic [LANES-1:0]                       in_sync,
   input logic [LANES*DATA_W-1:0]                out_data,
   input logic [LANES-1:0]                       out_ctrl,
   input logic                                   out_valid,
   input logic                                   aligned,
   input logic [LANES*($clog2(FIFO_DEPTH)+1)-1:0] fifo_level
);
   localparam int unsigned LVW = $clog2(FIFO_DEPTH) + 1;

   logic [LANES-1:0] chk_mark;
   logic             col_full;

   always_comb begin
      for (int i = 0; i < LANES; i++) begin
         chk_mark[i] = out_ctrl[i] && (out_data[i*DATA_W +: DATA_W] == ALIGN_CODE);
      end
   end
   assign col_full = &chk_mark;

   AST_FIRST_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> col_full); // R2

   AST_SYNC_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      !(&in_sync) |=> (!out_valid && !aligned)); // R9

   AST_LOCK_ON_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(aligned) |-> $past(out_valid && col_full)); // R5

   AST_ALIGN_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      aligned |-> out_valid); // R7

   for (genvar g = 0; g < LANES; g++) begin : g_lvl
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         fifo_level[g*LVW +: LVW] <= LVW'(FIFO_DEPTH)); // R3
   end
endmodule

bind lane_deskew dsk_checker #(
   .LANES      (LANES),
   .DATA_W     (DATA_W),
   .FIFO_DEPTH (FIFO_DEPTH),
   .ALIGN_CODE (ALIGN_CODE)
) u_dsk_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_sync    (in_sync),
   .out_data   (out_data),
   .out_ctrl   (out_ctrl),
   .out_valid  (out_valid),
   .aligned    (aligned),
   .fifo_level (fifo_level)
);

// File: tb/tb_lane_deskew.sv
`timescale 1ns/1ps
module tb_lane_deskew;
   localparam int PER = 32;   // source column period of alignment characters

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_data = '0;
   logic [3:0]  in_ctrl = '0;
   logic [3:0]  in_sync = '1;
   logic [31:0] out_data;
   logic [3:0]  out_ctrl;
   logic        out_valid;
   logic        aligned;

   int checks = 0;
   int fails  = 0;
   int dly [4];
   int corr_lane, corr_lo, corr_hi;
   int cs_a, cs_b, cs_switch;
   int drop_edge, drop_lane;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   lane_deskew dut (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_ctrl(in_ctrl),
      .in_sync(in_sync), .out_data(out_data), .out_ctrl(out_ctrl),
      .out_valid(out_valid), .aligned(aligned)
   );

   // Source column c on lane l: {ctrl, data}
   function automatic logic [8:0] src(int c, int l);
      if (c < 0) return 9'h000;
      if (c % PER == 4) begin
         int m = c / PER;
         if (l == corr_lane && m >= corr_lo && m <= corr_hi) return {1'b0, 8'h7C};
         return {1'b1, 8'h7C};
      end
      if (c % PER == 9) return {1'b1, 8'hBC};
      return {1'b0, 8'((c * 13 + l * 61 + 5) & 255)};
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic drive(int t);
      for (int l = 0; l < 4; l++) begin
         logic [8:0] s = src(t - dly[l], l);
         in_data[l*8 +: 8] = s[7:0];
         in_ctrl[l]        = s[8];
         in_sync[l]        = !(t == drop_edge && l == drop_lane);
      end
   endtask

   // Expected state after edge t1, from skews and first accepted column
   task automatic check_after(int t1, string tag);
      int dmax = 0;
      int cs   = (t1 >= cs_switch) ? cs_b : cs_a;
      bit ev, ea;
      for (int l = 0; l < 4; l++) if (dly[l] > dmax) dmax = dly[l];
      ev = (t1 >= cs + dmax + 1);
      ea = (t1 >= cs + dmax + 98);
      check(out_valid == ev && aligned == ea, tag, $sformatf("valid/aligned after edge %0d", t1),
            {out_valid, aligned}, {ev, ea});
      if (ev) begin
         int col = t1 - dmax - 1;
         for (int l = 0; l < 4; l++) begin
            logic [8:0] e = src(col, l);
            check({out_ctrl[l], out_data[l*8 +: 8]} == e, tag,
                  $sformatf("lane %0d column %0d", l, col),
                  {out_ctrl[l], out_data[l*8 +: 8]}, e);
         end
      end
   endtask

   task automatic run_case(string tag, int ncyc);
      @(negedge clk);
      rst_n = 1'b0;
      in_data = '0; in_ctrl = '0; in_sync = '1;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && aligned == 1'b0, "R10", "reset state",
            {out_valid, aligned}, 0);
      rst_n = 1'b1;
      drive(0);
      for (int t = 1; t < ncyc; t++) begin
         @(negedge clk);
         check_after(t - 1, tag);
         drive(t);
      end
   endtask

   task automatic setup(int d0, int d1, int d2, int d3, int cl, int clo, int chi,
                        int ca, int cb, int csw, int de, int dl);
      dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
      corr_lane = cl; corr_lo = clo; corr_hi = chi;
      cs_a = ca; cs_b = cb; cs_switch = csw;
      drop_edge = de; drop_lane = dl;
   endtask

   initial begin
      // R2 R5: moderate skew, clean stream
      setup(0, 3, 7, 1, -1, 0, 0, 4, 4, 0, -1, 0);
      run_case("R2,R5", 160);
      // R3: skew of depth-1
      setup(15, 0, 8, 4, -1, 0, 0, 4, 4, 0, -1, 0);
      run_case("R3", 160);
      // R4: skew of depth, late marker lands on the restart edge
      setup(0, 16, 5, 2, -1, 0, 0, 100000, 100000, 0, -1, 0);
      run_case("R4", 200);
      // R6: one broken column after lock
      setup(0, 3, 7, 1, 2, 4, 4, 4, 4, 0, -1, 0);
      run_case("R6", 220);
      // R7: four broken columns after lock, then reacquire at column 260
      setup(0, 3, 7, 1, 2, 4, 7, 4, 260, 237, -1, 0);
      run_case("R7", 400);
      // R8: broken column before lock, reacquire at column 68
      setup(0, 3, 7, 1, 1, 1, 1, 4, 68, 45, -1, 0);
      run_case("R8", 200);
      // R9: sync drop on the edge that would complete lock
      setup(0, 3, 7, 1, -1, 0, 0, 4, 132, 109, 109, 2);
      run_case("R9", 260);
      // R1: lane 3's first 0x7C has ctrl=0, so it must not start
      setup(0, 3, 7, 1, 3, 0, 0, 36, 36, 0, -1, 0);
      run_case("R1", 170);
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule